// File: doc/BRIEF.md
# Phase-Stepped Square Wave Synthesizer

This block turns a fast reference clock into a square wave of programmable frequency. It uses a phase accumulator and has no analog stage. On every clock edge the accumulator grows by a tuning word, and the square wave is the top bit of the accumulator. With a 32-bit accumulator on a 120 MHz clock, the output frequency is `tune_word * 120 MHz / 2^32`. A tuning word of 0x05555555 gives about 2.5 MHz.

An external timing engine produces a fresh time solution about once per second. At each solution it can push the accumulator phase forward or back by a signed amount, using a one-cycle strobe. That step is added in the same cycle as the ordinary increment. The local clock may drift, but the average output frequency still follows the engine's solution. Output edges can only fall on accumulator clock edges, so edge placement is quantized to one clock period.

Top module: `phase_step_nco`

## Requirements
- R1: While `rst_n` is low, the accumulator is cleared to zero at each clock edge and `sq_out` is low.
- R2: On a clock edge with `rst_n` high and `corr_stb` low, the phase becomes the previous phase plus `tune_word`, modulo 2^32.
- R3: On a clock edge with `corr_stb` high, the phase becomes the previous phase plus `tune_word` plus the two's-complement value on `corr_step`, modulo 2^32. Both are applied in the same cycle.
- R4: When `corr_stb` is low, the value on `corr_step` has no effect on the phase or on `sq_out`.
- R5: A new `tune_word` is used from the first clock edge at which it is presented. The phase is not reset when it changes.
- R6: The phase wraps modulo 2^32. With `tune_word` zero and no strobe, `sq_out` does not change.
- R7: `sq_out` equals bit 31 of the phase, so it is high exactly when the phase is at least 2^31. It changes only at clock edges.
- R8: With `tune_word` = 0x05555555, the output completes one period about every 48 clocks, which is near 2.5 MHz at a 120 MHz clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Accumulator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tune_word | input | 32 | Phase increment added on every edge |
| corr_step | input | 32 | Signed phase step, two's complement |
| corr_stb | input | 1 | Applies `corr_step` on this edge |
| sq_out | output | 1 | Square wave output, taken from the phase MSB |

## Verification
Every input acts on the clock edge that samples it. The phase is a single register, and `sq_out` follows it with no further stage, so every result is due in the cycle after the stimulus edge. The bench drives inputs on the falling edge. A reference phase, kept as a plain 32-bit integer, is advanced at each rising edge. The bench compares `sq_out` with the model one time unit after that edge, on every cycle. Directed phases test each requirement, including a large correction while the strobe is low, zero tuning, wrap-around, and a rising-edge count at the 2.5 MHz setting.

// File: rtl/phase_step_nco.sv
module phase_step_nco #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] tune_word,
  input  logic [ACC_W-1:0] corr_step,
  input  logic             corr_stb,
  output logic             sq_out
);

  localparam int MSB = ACC_W - 1;

  logic [ACC_W-1:0] phase;
  logic [ACC_W-1:0] step_sel;

  assign step_sel = corr_stb ? corr_step : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase + tune_word + step_sel;
  end

  assign sq_out = phase[MSB];

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (phase == '0 && !sq_out)); // R1

  AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !corr_stb) |=> phase == $past(phase) + $past(tune_word)); // R2

  AST_CORR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && corr_stb) |=> phase == $past(phase) + $past(tune_word) + $past(corr_step)); // R3

  AST_ZERO_TUNE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !corr_stb && tune_word == '0) |=> $stable(sq_out)); // R6

endmodule

// File: tb/tb_phase_step_nco.sv
module tb_phase_step_nco;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tune_word = '0;
  logic [31:0] corr_step = '0;
  logic        corr_stb = 1'b0;
  logic        sq_out;

  int total = 0;
  int bad = 0;
  logic [31:0] model = '0;
  string cur_req = "R1";
  int rises = 0;
  logic prev_out = 1'b0;
  bit done = 0;

  phase_step_nco dut (
    .clk(clk), .rst_n(rst_n), .tune_word(tune_word),
    .corr_step(corr_step), .corr_stb(corr_stb), .sq_out(sq_out)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: sq_out=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model = '0;
    else model = model + tune_word + (corr_stb ? corr_step : 32'd0);
    #1;
    if (!done) begin
      check(cur_req, sq_out, model[31]);
      if (sq_out && !prev_out) rises++;
      prev_out = sq_out;
    end
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    run(3);
    cur_req = "R1";
    check("R1", sq_out, 1'b0);
    // R2: plain increments, quarter-turn steps
    @(negedge clk); rst_n = 1'b1; tune_word = 32'h4000_0000; cur_req = "R2";
    run(10);
    // R7: MSB follows phase, a fine step
    tune_word = 32'h0123_4567; cur_req = "R7";
    run(40);
    // R3: positive and negative corrections
    cur_req = "R3";
    corr_step = 32'h8000_0000; corr_stb = 1'b1;
    @(negedge clk); corr_stb = 1'b0;
    run(3);
    corr_step = 32'hC000_0000; corr_stb = 1'b1;
    @(negedge clk); corr_stb = 1'b0;
    run(3);
    corr_step = 32'h3000_0000; corr_stb = 1'b1;
    run(2); corr_stb = 1'b0;
    run(3);
    // R4: large step presented without strobe
    cur_req = "R4";
    tune_word = 32'd0;
    corr_step = 32'h8000_0000;
    run(6);
    corr_step = 32'h7FFF_FFFF;
    run(6);
    corr_step = '0;
    // R6: zero tune holds output; wrap with large step
    cur_req = "R6";
    run(8);
    tune_word = 32'hF000_0000;
    run(20);
    // R5: change tune mid-stream without phase reset
    cur_req = "R5";
    tune_word = 32'h1000_0000;
    run(5);
    tune_word = 32'h2000_0000;
    run(5);
    tune_word = 32'h0800_0000;
    run(5);
    // R1: reset mid-run
    cur_req = "R1";
    rst_n = 1'b0;
    run(2);
    check("R1", sq_out, 1'b0);
    // R8: 2.5 MHz setting, count rising edges over 4800 clocks
    rst_n = 1'b1; tune_word = 32'h0555_5555; cur_req = "R8";
    rises = 0; prev_out = 1'b0;
    run(4800);
    total++;
    if (rises < 99 || rises > 100) begin
      bad++;
      $display("FAIL R8: rising edges=%0d expected=100", rises);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule